// File: doc/BRIEF.md
# OSD Display-Memory Write Stream Decoder

This block sits behind the byte receiver of an on-screen-display controller's serial port. It turns the incoming byte stream into write commands for a character display memory that is 15 rows high and has up to 31 addressable columns. Each accepted byte is classified as a row address, a column address or a data byte, from its top bits and from what came before it. Every data byte yields one registered write with a row, a column, a plane select and a 9-bit word.

Three transfer formats share one state machine. In the first format, every write sends its own row and column. In the second, one row is followed by repeated column/data pairs. In the third, a row and a column are sent once and then only data follows, and the address advances on its own after each write. Once the stream has entered the third format it stays there until the frame enable drops.

Dropping the frame enable returns the decoder to its start state and clears all address state.

Top module: `osd_write_decoder`

## Requirements
- R1: After reset, and while no row byte has been seen since reset or since the frame enable last dropped, no write is issued and every byte whose bit 7 is 0 is ignored.
- R2: Outside the streaming format, a byte with bit 7 = 1 is a row byte. Its bit 5 picks the plane (0 = character-address plane, 1 = attribute plane). The row number is bits 3..0 in the address plane and bits 4..0 in the attribute plane.
- R3: A byte with bit 7 = 0 that follows a row byte or a data byte of the per-write formats is a column byte. Its bits 4..0 give the column. Its bit 6 = 0 keeps the per-write formats, and bit 6 = 1 enters the streaming format.
- R4: The byte after a column byte is a data byte, whatever its value. The write it causes carries the latched row and column.
- R5: In the address plane, bit 8 of the written word is bit 5 of the most recent column byte, and it persists across later data bytes. In the attribute plane, bit 8 is 0.
- R6: Once a column byte with bit 6 = 1 is accepted, every later byte is data, including bytes with bit 7 = 1, until the frame enable drops.
- R7: In the streaming format, the column advances by one after each write. From column 30 it wraps to 0 and the row advances by one, and row 14 wraps to row 0.
- R8: While frame_en is 0, any offered byte is ignored, and the decoder returns to its start state with row, column, plane and bank cleared.
- R9: wr_en is a one-cycle pulse that rises on the clock edge after the data byte is accepted. There is exactly one pulse per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Transfer enable; low clears the decoder |
| byte_valid | input | 1 | byte_data holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| wr_en | output | 1 | Write strobe, one cycle per data byte |
| wr_row | output | 5 | Write row |
| wr_col | output | 5 | Write column |
| wr_attr | output | 1 | Plane select: 1 = attribute plane |
| wr_data | output | 9 | Write word; bit 8 is the font bank |

## Verification
The embedded properties check on every cycle that:
- no write follows a cycle with the enable low;
- a write only follows an accepted data byte;
- attribute-plane words never carry a bank bit;
- the streaming state is never left without a clear;
- the column and row wrap at their limits.

Only the bench's byte sequences can show the rest:
- that bytes are classified correctly in each format and across format changes;
- that row bits are taken per plane;
- that the bank bit persists;
- that bytes before the first row are ignored.

// File: rtl/osd_dec_pkg.sv
// Shared types for the OSD write stream decoder.
// Assumes: byte-level input, one byte per accepted cycle.
package osd_dec_pkg;
    // Position in the transfer: what the last accepted byte was.
    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_ROW     = 3'd1,
        ST_COL_AB  = 3'd2,
        ST_DATA_AB = 3'd3,
        ST_COL_C   = 3'd4,
        ST_DATA_C  = 3'd5
    } fmt_state_t;

    // Classification of the byte on the input this cycle.
    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_ROW  = 2'd1,
        BK_COL  = 2'd2,
        BK_DATA = 2'd3
    } byte_kind_t;
endpackage

// File: rtl/osd_fmt_fsm.sv
// Transfer-format state machine.
// Classifies each accepted byte from its two top bits and the current state.
// Flags data bytes of the streaming format so that the address tracker can advance.
// Assumes: clr is a synchronous clear that wins over acceptance.
module osd_fmt_fsm
    import osd_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       acc,
    input  logic [1:0] top_bits,      // byte bits 7..6
    output byte_kind_t kind,
    output logic       stream_data
);
    fmt_state_t state_q;
    fmt_state_t state_d;
    logic       in_stream;

    assign in_stream = (state_q == ST_COL_C) || (state_q == ST_DATA_C);

    // Classify the current byte from the top bits and the state.
    always_comb begin
        kind = BK_NONE;
        if (acc) begin
            case (state_q)
                ST_INIT:    kind = top_bits[1] ? BK_ROW : BK_NONE;
                ST_ROW:     kind = top_bits[1] ? BK_ROW : BK_COL;
                ST_COL_AB:  kind = BK_DATA;
                ST_DATA_AB: kind = top_bits[1] ? BK_ROW : BK_COL;
                ST_COL_C:   kind = BK_DATA;
                ST_DATA_C:  kind = BK_DATA;
                default:    kind = BK_NONE;
            endcase
        end
    end

    assign stream_data = (kind == BK_DATA) && in_stream;

    // Derive the next state from the classified byte.
    always_comb begin
        state_d = state_q;
        case (kind)
            BK_ROW:  state_d = ST_ROW;
            BK_COL:  state_d = top_bits[0] ? ST_COL_C : ST_COL_AB;
            BK_DATA: state_d = in_stream ? ST_DATA_C : ST_DATA_AB;
            default: state_d = state_q;
        endcase
    end

    // State register with reset and frame clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state_q <= ST_INIT;
        else               state_q <= state_d;
    end

    // R8
    clr_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_INIT));

    // R6
    stream_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DATA_C) && !clr) |=> (state_q == ST_DATA_C));

    // R6
    stream_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COL_C) && !clr) |=> in_stream);
endmodule

// File: rtl/osd_addr_track.sv
// Address tracker: holds the row, column, plane and font-bank state.
// Row and column bytes load it. Streaming data advances the column and row with wrap.
// Assumes: byte kinds come from osd_fmt_fsm in the same cycle.
module osd_addr_track
    import osd_dec_pkg::*;
#(
    parameter int ROW_W    = 5,
    parameter int COL_W    = 5,
    parameter int NUM_ROWS = 15,
    parameter int NUM_COLS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  byte_kind_t       kind,
    input  logic             stream_data,
    input  logic [5:0]       low_bits,    // byte bits 5..0
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             plane_q,
    output logic             bank_q
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    logic [ROW_W-1:0] row_byte;
    logic             col_wrap;

    assign row_byte = low_bits[5] ? ROW_W'(low_bits[4:0]) : ROW_W'(low_bits[3:0]);
    assign col_wrap = (col_q == LAST_COL);

    // Load the row and plane from row bytes; advance the row on a streaming wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row_q   <= '0;
            plane_q <= 1'b0;
        end else if (kind == BK_ROW) begin
            row_q   <= row_byte;
            plane_q <= low_bits[5];
        end else if (stream_data && col_wrap) begin
            row_q   <= (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
        end
    end

    // Load the column and bank from column bytes; advance the column while streaming.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col_q  <= '0;
            bank_q <= 1'b0;
        end else if (kind == BK_COL) begin
            col_q  <= COL_W'(low_bits[4:0]);
            bank_q <= low_bits[5];
        end else if (stream_data) begin
            col_q  <= col_wrap ? '0 : col_q + COL_W'(1);
        end
    end

    // R7
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_data && !clr && (col_q == LAST_COL)) |=> (col_q == '0));

    // R7
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_data && !clr && (col_q == LAST_COL) && (row_q == LAST_ROW)) |=> (row_q == '0));
endmodule

// File: rtl/osd_write_stage.sv
// Output register stage: captures one write per data byte.
// The write carries the tracker's current address and the word built from the byte and the bank.
// Assumes: the address inputs hold the pre-increment values in the firing cycle.
module osd_write_stage #(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic              plane_in,
    input  logic              bank_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic              wr_attr,
    output logic [BYTE_W:0]   wr_data
);
    // Register the strobe and the write payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_attr <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= fire;
            if (fire) begin
                wr_row  <= row_in;
                wr_col  <= col_in;
                wr_attr <= plane_in;
                wr_data <= {(plane_in ? 1'b0 : bank_in), byte_in};
            end
        end
    end

    // R9
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(fire));

    // R5
    attr_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_attr) |-> (wr_data[BYTE_W] == 1'b0));
endmodule

// File: rtl/osd_write_decoder.sv
// Top level: serial-byte to display-memory write decoder.
// Gates byte acceptance with the frame enable and links the format state machine,
// the address tracker and the output stage.
// Assumes: one byte per byte_valid cycle; a low frame_en acts as a synchronous clear.
module osd_write_decoder
    import osd_dec_pkg::*;
#(
    parameter int ROW_W    = 5,
    parameter int COL_W    = 5,
    parameter int NUM_ROWS = 15,
    parameter int NUM_COLS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic             wr_attr,
    output logic [8:0]       wr_data
);
    localparam int BYTE_W = 8;

    byte_kind_t       kind;
    logic             stream_data;
    logic             acc;
    logic             clr;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             plane_q;
    logic             bank_q;

    assign clr = !frame_en;
    assign acc = byte_valid && frame_en;

    osd_fmt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .acc         (acc),
        .top_bits    (byte_data[7:6]),
        .kind        (kind),
        .stream_data (stream_data)
    );

    osd_addr_track #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .kind        (kind),
        .stream_data (stream_data),
        .low_bits    (byte_data[5:0]),
        .row_q       (row_q),
        .col_q       (col_q),
        .plane_q     (plane_q),
        .bank_q      (bank_q)
    );

    osd_write_stage #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BYTE_W (BYTE_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (kind == BK_DATA),
        .row_in   (row_q),
        .col_in   (col_q),
        .plane_in (plane_q),
        .bank_in  (bank_q),
        .byte_in  (byte_data),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_attr  (wr_attr),
        .wr_data  (wr_data)
    );

    // R8
    disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> !wr_en);
endmodule

// File: tb/osd_write_decoder_test.sv
// Scoreboard bench: the driver queues the expected writes, and the monitor compares them as they appear.
module osd_write_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_en = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       wr_en;
    logic [4:0] wr_row;
    logic [4:0] wr_col;
    logic       wr_attr;
    logic [8:0] wr_data;

    int    n_checks = 0;
    int    n_fails  = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];
    string       phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    osd_write_decoder uut (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_attr(wr_attr), .wr_data(wr_data)
    );

    // Queue one expected write: {row, col, attr, data}.
    task automatic expect_wr(input string req, input int r, input int c,
                             input bit a, input int d);
        exp_q.push_back({5'(r), 5'(c), a, 9'(d)});
        tag_q.push_back(req);
    endtask

    // Offer one byte for a single cycle; called at a falling edge.
    task automatic send(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // Let outstanding writes appear, then require that none are still expected.
    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL %s pending writes actual=%0d expected=0", req, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Monitor: pop and compare each write strobe away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL %s unexpected write actual=%h expected=none",
                         phase, {wr_row, wr_col, wr_attr, wr_data});
            end else begin
                automatic logic [19:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if ({wr_row, wr_col, wr_attr, wr_data} !== e) begin
                    n_fails++;
                    $display("FAIL %s actual row=%0d col=%0d attr=%0d data=%h expected row=%0d col=%0d attr=%0d data=%h",
                             t, wr_row, wr_col, wr_attr, wr_data,
                             e[19:15], e[14:10], e[9], e[8:0]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        n_fails++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (wr_en !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 wr_en in reset actual=%b expected=0", wr_en);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (wr_en !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 wr_en after reset actual=%b expected=0", wr_en);
        end

        // R1: bytes with bit7=0 before any row are ignored
        phase = "R1";
        send(8'h05); send(8'h41); send(8'h25);
        drain("R1");

        // R2 R3 R4 R5: per-write format, both planes
        phase = "R2";
        send(8'h83); send(8'h25);
        expect_wr("R5", 3, 5, 1'b0, 9'h141); send(8'h41);
        send(8'h9C); send(8'h01);
        expect_wr("R2", 12, 1, 1'b0, 9'h0FF); send(8'hFF);
        send(8'hA2); send(8'h1E);
        expect_wr("R2", 2, 30, 1'b1, 9'h007); send(8'h07);
        send(8'hA4); send(8'h23);
        expect_wr("R5", 4, 3, 1'b1, 9'h055); send(8'h55);
        // row followed by another row
        send(8'h81); send(8'h84); send(8'h00);
        expect_wr("R2", 4, 0, 1'b0, 9'h012); send(8'h12);
        // R4: data byte with bit7=1 after a column
        send(8'h80); send(8'h09);
        expect_wr("R4", 0, 9, 1'b0, 9'h0C3); send(8'hC3);
        drain("R4");

        // R3: one row, repeated column/data pairs, then back to per-write
        phase = "R3";
        send(8'h81); send(8'h02);
        expect_wr("R3", 1, 2, 1'b0, 9'h010); send(8'h10);
        send(8'h03);
        expect_wr("R3", 1, 3, 1'b0, 9'h011); send(8'h11);
        send(8'h24);
        expect_wr("R5", 1, 4, 1'b0, 9'h199); send(8'h99);
        send(8'h87); send(8'h06);
        expect_wr("R3", 7, 6, 1'b0, 9'h020); send(8'h20);

        // R6 R7: streaming entered from a data byte; bank persists; wrap at col 30
        phase = "R6";
        send(8'h7D);
        expect_wr("R7", 7, 29, 1'b0, 9'h101); send(8'h01);
        expect_wr("R6", 7, 30, 1'b0, 9'h185); send(8'h85);
        expect_wr("R7", 8, 0, 1'b0, 9'h102); send(8'h02);
        expect_wr("R6", 8, 1, 1'b0, 9'h140); send(8'h40);
        drain("R6");

        // R8: drop the enable with a byte offered; the decoder returns to start
        phase = "R8";
        frame_en = 1'b0; byte_valid = 1'b1; byte_data = 8'hA0;
        @(negedge clk);
        n_checks++;
        if (wr_en !== 1'b0) begin
            n_fails++;
            $display("FAIL R8 wr_en while disabled actual=%b expected=0", wr_en);
        end
        frame_en = 1'b1; byte_valid = 1'b0;
        @(negedge clk);
        send(8'h1F); send(8'h33);
        drain("R8");

        // R7: streaming from a row, row 14 wraps to row 0 in the attribute plane
        phase = "R7";
        send(8'hAE); send(8'h5E);
        expect_wr("R7", 14, 30, 1'b1, 9'h00A); send(8'h0A);
        expect_wr("R7", 0, 0, 1'b1, 9'h00B); send(8'h0B);
        drain("R7");

        // R9: streaming bytes offered with idle gaps still give one pulse each
        phase = "R9";
        expect_wr("R9", 0, 1, 1'b1, 9'h0EE); send(8'hEE);
        repeat (2) @(negedge clk);
        expect_wr("R9", 0, 2, 1'b1, 9'h0DD); send(8'hDD);
        drain("R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule